// File: doc/BRIEF.md
# Sticky Event Status Bank with Selectable Clear Policy

This block keeps a register of sticky status flags. Each flag is set by a rising edge on its own event input and then stays set until the host clears it. One control bit chooses how the host clears flags, and the choice applies to the whole register. In acknowledge-by-write mode the host writes a 1 to each flag it wants to clear. In clear-on-read mode a read of the status register returns the flags and then clears all of them.

The host reaches three registers through an address, separate read and write enables, write data and combinational read data: the status flags, an interrupt mask and the policy control. An interrupt output is high while any flag that is enabled in the mask is set. When a new event arrives in the same cycle that clears its flag, the flag stays set, so no event is lost.

Top module: `sticky_status_bank`

## Requirements
- R1: After reset all status flags, the mask and the policy bit are 0, every readable register returns 0, and irq_o is low.
- R2: A flag sets on the clock edge after its event input goes from 0 to 1, compared with the value in the previous cycle. An input held at 1 does not set its flag again after the flag is cleared.
- R3: A set flag stays set until the active clear policy clears it.
- R4: With the policy bit at 0, a write to address 0 clears exactly the flags whose write-data bit is 1. All other flags are unchanged, and reads do not clear anything.
- R5: With the policy bit at 1, a read of address 0 (rd_en_i high) returns the flags as they were before the read, and all flags are cleared on that clock edge.
- R6: With the policy bit at 1, writes to address 0 have no effect on the flags.
- R7: A rising event in the same cycle as a clear of its flag, under either policy, leaves the flag set.
- R8: Address 2 bit 0 holds the policy bit. It reads back in bit 0, and the other bits read 0. A new policy applies to accesses in the cycles after the write.
- R9: Address 1 holds the interrupt mask and reads back as written. irq_o is the OR over all bits of the flags ANDed with the mask. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register select: 0 status, 1 mask, 2 policy |
| wr_en_i | input | 1 | Write enable for the selected register |
| rd_en_i | input | 1 | Read strobe, used by clear-on-read |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data of the selected register |
| event_i | input | 16 | Per-flag event inputs |
| irq_o | output | 1 | OR of masked flags |

## Verification
An edge detector with a wrong history value either sets a flag twice for one level or misses a rising edge. Either error shows in the status read one cycle after the event. A wrong clear decode, or a policy bit stored wrongly, changes the status read in the cycle after the clearing access. Because irq_o follows the flags and the mask combinationally, a flag that was wrongly kept or wrongly dropped also shows on irq_o in that same cycle. The bench applies each clear, with and without a colliding event, and then reads the status back at once.

// File: rtl/sticky_pkg.sv
package sticky_pkg;
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_POLICY = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam logic POLICY_W1C = 1'b0;
    localparam logic POLICY_COR = 1'b1;
endpackage

// File: rtl/sticky_rise_detect.sv
module sticky_rise_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_i,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] hist;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hist = ev_i;
        rise_o    = ev_i & ~st_q.hist;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sticky_latch_bank.sv
module sticky_latch_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] lat_o
);
    typedef struct packed {
        logic [W-1:0] lat;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lat = rise_i | (st_q.lat & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_o = st_q.lat;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // R3: a flag with no clear pending holds
        a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.lat[b] && !clr_i[b]) |=> st_q.lat[b]);
        // R7: a rising event always lands, even against a clear
        a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            rise_i[b] |=> st_q.lat[b]);
    end
endmodule

// File: rtl/sticky_ctrl_regs.sv
module sticky_ctrl_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_mask_i,
    input  logic         wr_policy_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o,
    output logic         policy_o
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic         policy;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_mask_i)   st_d.mask   = wdata_i;
        if (wr_policy_i) st_d.policy = wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o   = st_q.mask;
    assign policy_o = st_q.policy;

    // R8: policy changes only through a policy write
    a_r8_policy_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_policy_i |=> $stable(policy_o));
endmodule

// File: rtl/sticky_status_bank.sv
module sticky_status_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr_i,
    input  logic         wr_en_i,
    input  logic         rd_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    input  logic [W-1:0] event_i,
    output logic         irq_o
);
    import sticky_pkg::*;

    reg_sel_e     sel;
    logic [W-1:0] rise, clr, lat, mask;
    logic         policy;
    logic         wr_status, rd_status;

    assign sel       = reg_sel_e'(addr_i);
    assign wr_status = wr_en_i && (sel == SEL_STATUS);
    assign rd_status = rd_en_i && (sel == SEL_STATUS);

    sticky_rise_detect #(.W(W)) u_rise (
        .clk(clk), .rst_n(rst_n), .ev_i(event_i), .rise_o(rise)
    );

    sticky_ctrl_regs #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_mask_i(wr_en_i && (sel == SEL_MASK)),
        .wr_policy_i(wr_en_i && (sel == SEL_POLICY)),
        .wdata_i(wdata_i), .mask_o(mask), .policy_o(policy)
    );

    always_comb begin
        clr = '0;
        if (policy == POLICY_W1C) begin
            if (wr_status) clr = wdata_i;
        end else begin
            if (rd_status) clr = '1;
        end
    end

    sticky_latch_bank #(.W(W)) u_bank (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .clr_i(clr), .lat_o(lat)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: rdata_o = lat;
            SEL_MASK:   rdata_o = mask;
            SEL_POLICY: rdata_o = {{(W-1){1'b0}}, policy};
            default:    rdata_o = '0;
        endcase
    end

    assign irq_o = |(lat & mask);

    // R4: acknowledge-by-write clears the written ones unless an event lands
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POLICY_W1C && wr_status) |=>
            ((lat & $past(wdata_i) & ~$past(rise)) == '0));
    // R4: a read does not clear in acknowledge-by-write mode
    a_r4_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POLICY_W1C && !wr_status) |=> (lat == ($past(lat) | $past(rise))));
    // R5: clear-on-read leaves only fresh events
    a_r5_cor_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POLICY_COR && rd_status) |=> (lat == $past(rise)));
    // R6: writes ignored in clear-on-read mode
    a_r6_cor_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == POLICY_COR && !rd_status) |=> (lat == ($past(lat) | $past(rise))));
endmodule

// File: tb/sticky_status_bank_test.sv
`timescale 1ns/1ps
module sticky_status_bank_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   addr = '0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wdata = '0, ev = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sticky_status_bank #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .wdata_i(wdata), .rdata_o(rdata), .event_i(ev), .irq_o(irq)
    );

    // op: 0 idle, 1 write, 2 read
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  ad;
        logic [15:0] wd;
        logic [15:0] ev;
        logic [15:0] exp_rd;
        logic [15:0] exp_st;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 2'd1, 16'h00FF, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R9 mask low byte
        '{2'd0, 2'd0, 16'h0000, 16'h0003, 16'h0000, 16'h0003, 1'b1}, // R2 rise
        '{2'd0, 2'd0, 16'h0000, 16'h0003, 16'h0000, 16'h0003, 1'b1}, // R3 held
        '{2'd1, 2'd0, 16'h0001, 16'h0000, 16'h0000, 16'h0002, 1'b1}, // R4 partial clear
        '{2'd2, 2'd0, 16'h0000, 16'h0000, 16'h0002, 16'h0002, 1'b1}, // R4 read keeps
        '{2'd0, 2'd0, 16'h0000, 16'h0100, 16'h0000, 16'h0102, 1'b1}, // R2 new bit
        '{2'd1, 2'd0, 16'h0102, 16'h0100, 16'h0000, 16'h0000, 1'b0}, // R2 held level no relatch
        '{2'd0, 2'd0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0}, // R3 idle
        '{2'd1, 2'd0, 16'hFFFF, 16'h8000, 16'h0000, 16'h8000, 1'b0}, // R7 W1C collision
        '{2'd1, 2'd1, 16'hFF00, 16'h0000, 16'h0000, 16'h8000, 1'b1}, // R9 mask high byte
        '{2'd1, 2'd2, 16'h0001, 16'h0000, 16'h0000, 16'h8000, 1'b1}, // R8 to COR
        '{2'd1, 2'd0, 16'hFFFF, 16'h0000, 16'h0000, 16'h8000, 1'b1}, // R6 write ignored
        '{2'd2, 2'd0, 16'h0000, 16'h0000, 16'h8000, 16'h0000, 1'b0}, // R5 read clears
        '{2'd0, 2'd0, 16'h0000, 16'h0410, 16'h0000, 16'h0410, 1'b1}, // R2 two bits
        '{2'd2, 2'd0, 16'h0000, 16'h0000, 16'h0410, 16'h0000, 1'b0}, // R5 read clears
        '{2'd2, 2'd0, 16'h0000, 16'h0020, 16'h0000, 16'h0020, 1'b0}, // R7 COR collision
        '{2'd1, 2'd2, 16'h0000, 16'h0000, 16'h0000, 16'h0020, 1'b0}, // R8 back to W1C
        '{2'd2, 2'd0, 16'h0000, 16'h0000, 16'h0020, 16'h0020, 1'b0}  // R4 read keeps
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_read(input logic [1:0] a);
        @(negedge clk);
        addr = a; wr_en = 1'b0; rd_en = 1'b0;
        #1;
    endtask

    task automatic do_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        rst_n = 1'b1;
        idle_read(2'd0); check("R1 status", rdata, '0);
        check("R1 irq", {15'd0, irq}, 16'd0);
        idle_read(2'd1); check("R1 mask", rdata, '0);
        idle_read(2'd2); check("R1 policy", rdata, '0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ev = TBL[i].ev; addr = TBL[i].ad; wdata = TBL[i].wd;
            wr_en = (TBL[i].op == 2'd1); rd_en = (TBL[i].op == 2'd2);
            #1;
            if (TBL[i].op == 2'd2) check($sformatf("R5/R4 read data v%0d", i), rdata, TBL[i].exp_rd);
            idle_read(2'd0);
            check($sformatf("R2-7 status v%0d", i), rdata, TBL[i].exp_st);
            check($sformatf("R9 irq v%0d", i), {15'd0, irq}, {15'd0, TBL[i].exp_irq});
        end

        // R8 policy readback: only bit 0 kept
        do_write(2'd2, 16'hFFFF);
        idle_read(2'd2); check("R8 policy readback", rdata, 16'h0001);
        // R9 mask readback and unused address
        idle_read(2'd1); check("R9 mask readback", rdata, 16'hFF00);
        idle_read(2'd3); check("R9 addr 3 zero", rdata, 16'h0000);

        // R1 reset in the middle of operation
        @(negedge clk); ev = 16'h4000;
        idle_read(2'd0); check("R2 pre-reset latch", rdata, 16'h4020);
        rst_n = 1'b0; #1;
        check("R1 status after reset", rdata, '0);
        check("R1 irq after reset", {15'd0, irq}, 16'd0);
        addr = 2'd2; #1; check("R1 policy after reset", rdata, '0);
        ev = '0;
        @(negedge clk); rst_n = 1'b1;
        idle_read(2'd0); check("R3 stays clear", rdata, '0);

        done = 1'b1;
        finish_run();
    end
endmodule